// File: doc/BRIEF.md
# Converter Fault Supervisor with Auto-Restart

This block decides when a switching converter's power switch may operate. It watches per-cycle termination events from the PWM generator, three digital fault flags from the analog front end (excess clamp current at the supply pin, disable input above threshold, over-temperature), a level that reports operation pinned at the minimum switching frequency, and a supply-good level. From these it drives a PWM enable, a stepped cycle-by-cycle current-limit setpoint, and a code that names the fault currently being served.

Each fault source has its own qualification. Overload uses a cycle counter that counts up on current-limited cycles and back down on normal ones. Max-duty termination needs an unbroken run of cycles. Clamp current, the disable input and minimum-frequency operation are time filters. Over-temperature trips at once. A tripped fault stops switching for a fixed restart wait, which is shorter for the disable input. Every start is a soft-start ramp of the current limit. After an over-temperature wait, one probe cycle re-checks the temperature before a normal restart.

All timing is counted in ticks of an internal prescaler, so the same RTL serves both real-time and scaled simulation values.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is held or `supply_ok` is low, `pwm_en` is 0, `ilim_step` is 0 and `fault_code` is 0. In these conditions any trip or wait in progress is abandoned. Once `supply_ok` is high, a soft-start begins on the next clock.
- R2: A soft-start drives `ilim_step` to 1 on entry. It then rises by exactly one every `SS_STEP_TICKS` ticks up to `SS_STEPS`, and holds there for one more interval before normal running. In normal running `ilim_step` equals `SS_STEPS`.
- R3: Overload counter: each cycle end with `cyc_ilim` set adds one, and each cycle end without it subtracts one, never going below zero. Reaching `OVL_LIMIT` trips with code 4. An alternating limited/normal pattern never trips.
- R4: `at_fmin` held high for `MINF_TICKS` ticks while switching trips an overload (code 4).
- R5: `MAXD_LIMIT` consecutive cycle ends with `cyc_maxd` set trip with code 5. Any cycle end without it restarts the run from zero.
- R6: `clamp_hi` held for `CLAMP_TICKS` ticks in normal running trips with code 2. The flag is ignored for the whole soft-start.
- R7: `dis_hi` held for `DIS_TICKS` ticks while switching trips with code 3. Shorter excursions have no effect.
- R8: A trip drops `pwm_en` on the next clock. The restart wait lasts `DIS_RESTART_TICKS` for code 3 and `RESTART_TICKS` for all other codes. The wait always runs to its end even if the fault has already cleared, and it is followed by a soft-start from step 1.
- R9: `hot` while switching trips at once with code 1. After the wait, a probe runs with `pwm_en` 1 and `ilim_step` 1 until the next cycle end. If `hot` is still set at that cycle end, another full wait follows with code 1; otherwise a soft-start begins and the code clears.
- R10: Faults qualifying in the same clock are resolved in this order: over-temperature (1), clamp (2), disable (3), overload (4), max-duty (5).
- R11: `fault_code` holds the winning cause unchanged through the wait (and the probe), and returns to 0 when a soft-start begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Controller supply above its run threshold |
| cyc_end | input | 1 | One-clock pulse at the end of each switching cycle |
| cyc_ilim | input | 1 | With `cyc_end`: cycle was ended by the current limit |
| cyc_maxd | input | 1 | With `cyc_end`: cycle was ended by the duty limit |
| at_fmin | input | 1 | Pulse skipping has reached the minimum frequency |
| clamp_hi | input | 1 | Supply clamp current above its threshold |
| dis_hi | input | 1 | Disable input above its threshold |
| hot | input | 1 | Junction temperature above shutdown threshold |
| pwm_en | output | 1 | Switching allowed |
| ilim_step | output | $clog2(SS_STEPS+1) | Current-limit setpoint in eighths of full scale (0 = off) |
| fault_code | output | 3 | Cause of the current trip (0 none, 1 hot, 2 clamp, 3 disable, 4 overload, 5 max-duty) |

## Verification
A corrupted filter or cycle counter shows up as a trip one or more cycles early or late. The bench therefore probes each source just below its threshold and then at it, and watches `pwm_en` fall within two clocks of the qualifying event. A wrong restart limit or a wait that ends early is visible as an off-time outside a window of a few clocks around the expected tick count. A broken ramp shows as a skipped or repeated `ilim_step` value during soft-start. A wrong priority or a lost latch changes `fault_code` at the first sample taken in the wait.

// File: rtl/fsup_pkg.sv
// Shared types for the fault supervisor: controller states and fault cause codes.
// The numeric cause codes are visible at the top-level port and must not change.
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SOFT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_PROBE = 3'd4
    } fsup_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_HOT   = 3'd1,
        CAUSE_CLAMP = 3'd2,
        CAUSE_DIS   = 3'd3,
        CAUSE_OVL   = 3'd4,
        CAUSE_MAXD  = 3'd5
    } fsup_cause_e;

endpackage

// File: rtl/fsup_tick.sv
// Prescaler: emits a one-clock tick every DIV clocks.
// Assumes DIV >= 2. Free-running once out of reset.
module fsup_tick #(
    parameter int DIV = 5000,
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Count clocks and wrap at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DIV - 1));

endmodule

// File: rtl/fsup_filter.sv
// Time filter: trip is raised once 'level' has been continuously high
// for LIMIT ticks while 'en' is high. Any low level or disable clears it.
module fsup_filter #(
    parameter int LIMIT = 10,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic level,
    output logic trip
);

    logic [CW-1:0] cnt;

    assign trip = (cnt == CW'(LIMIT));

    // Accumulate ticks of uninterrupted level, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !level)
            cnt <= '0;
        else if (tick && !trip)
            cnt <= cnt + 1'b1;
    end

    assert_filter_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));

    assert_filter_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !level |=> !trip);

endmodule

// File: rtl/fsup_cyc_cnt.sv
// Per-switching-cycle fault counter. Two variants, chosen by UPDOWN:
//   1: up on a hit cycle, down (floor 0) on a clean cycle  (overload)
//   0: up on a hit cycle, cleared on a clean cycle         (consecutive run)
// trip is high while the count equals LIMIT. Assumes LIMIT >= 1.
module fsup_cyc_cnt #(
    parameter int LIMIT  = 10,
    parameter bit UPDOWN = 1'b0,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_end,
    input  logic hit,
    output logic trip
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;

    assign trip = (cnt == CW'(LIMIT));

    generate
        if (UPDOWN) begin : g_updown
            // Next count: step toward LIMIT on a hit, toward zero otherwise.
            always_comb begin
                nxt = cnt;
                if (cyc_end) begin
                    if (hit) begin
                        if (!trip) nxt = cnt + 1'b1;
                    end else if (cnt != '0) begin
                        nxt = cnt - 1'b1;
                    end
                end
            end
        end else begin : g_consec
            // Next count: extend the run on a hit, restart it otherwise.
            always_comb begin
                nxt = cnt;
                if (cyc_end) begin
                    if (!hit)      nxt = '0;
                    else if (!trip) nxt = cnt + 1'b1;
                end
            end
        end
    endgenerate

    // Hold the count; cleared whenever counting is not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else
            cnt <= nxt;
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));

    assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(cyc_end)) |-> $stable(cnt));

    assert_cnt_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(hit)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/fsup_ramp.sv
// Soft-start ramp. While 'en' is low the step is preset to 1. While high,
// the step rises by one every STEP_TICKS ticks up to STEPS; 'done' pulses at
// the end of the interval spent at STEPS. Assumes STEPS >= 1, STEP_TICKS >= 2.
module fsup_ramp #(
    parameter int STEPS      = 8,
    parameter int STEP_TICKS = 10,
    localparam int SW = $clog2(STEPS + 1),
    localparam int CW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    output logic [SW-1:0] step,
    output logic          done
);

    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(STEP_TICKS - 1));
    assign done = en && tick && last && (step == SW'(STEPS));

    // Advance the interval counter and the step value.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            step <= SW'(1);
            cnt  <= '0;
        end else if (tick) begin
            if (last) begin
                cnt <= '0;
                if (step != SW'(STEPS)) step <= step + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_ramp_unit_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> (step == $past(step) || step == $past(step) + 1'b1));

    assert_ramp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step >= SW'(1) && step <= SW'(STEPS));

endmodule

// File: rtl/fault_supervisor.sv
// Converter fault supervisor. Sequences soft-start, normal running, restart
// waits and the over-temperature probe cycle; qualifies each fault source
// with its own filter and latches the winning cause by fixed priority.
// Assumes cyc_ilim/cyc_maxd are valid only with cyc_end, and that all flag
// inputs are already synchronous to clk.
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int TICK_CLKS         = 5000,
    parameter int SS_STEPS          = 8,
    parameter int SS_STEP_TICKS     = 10,
    parameter int CLAMP_TICKS       = 5,
    parameter int DIS_TICKS         = 10,
    parameter int MINF_TICKS        = 2000,
    parameter int RESTART_TICKS     = 10000,
    parameter int DIS_RESTART_TICKS = 5000,
    parameter int OVL_LIMIT         = 3000,
    parameter int MAXD_LIMIT        = 10,
    localparam int SW    = $clog2(SS_STEPS + 1),
    localparam int RMAX  = (RESTART_TICKS > DIS_RESTART_TICKS) ? RESTART_TICKS : DIS_RESTART_TICKS,
    localparam int RW    = $clog2(RMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          cyc_end,
    input  logic          cyc_ilim,
    input  logic          cyc_maxd,
    input  logic          at_fmin,
    input  logic          clamp_hi,
    input  logic          dis_hi,
    input  logic          hot,
    output logic          pwm_en,
    output logic [SW-1:0] ilim_step,
    output logic [2:0]    fault_code
);

    fsup_state_e   state;
    fsup_cause_e   cause;
    fsup_cause_e   win;
    logic [RW-1:0] rcnt;
    logic [RW-1:0] rlim;
    logic          dis_wait;

    logic          tick;
    logic          active;
    logic          running;
    logic          trip_hot, trip_clamp, trip_dis, trip_minf, trip_ovl, trip_maxd;
    logic          trip_any;
    logic [SW-1:0] ramp_step;
    logic          ramp_done;

    assign active  = (state == ST_SOFT) || (state == ST_RUN);
    assign running = (state == ST_RUN);

    fsup_tick #(.DIV(TICK_CLKS)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    fsup_ramp #(.STEPS(SS_STEPS), .STEP_TICKS(SS_STEP_TICKS)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_SOFT),
        .tick (tick),
        .step (ramp_step),
        .done (ramp_done)
    );

    // Clamp filter runs only after soft-start has finished.
    fsup_filter #(.LIMIT(CLAMP_TICKS)) u_clamp (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .en   (running),
        .level(clamp_hi),
        .trip (trip_clamp)
    );

    fsup_filter #(.LIMIT(DIS_TICKS)) u_dis (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .en   (active),
        .level(dis_hi),
        .trip (trip_dis)
    );

    fsup_filter #(.LIMIT(MINF_TICKS)) u_minf (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .en   (active),
        .level(at_fmin),
        .trip (trip_minf)
    );

    fsup_cyc_cnt #(.LIMIT(OVL_LIMIT), .UPDOWN(1'b1)) u_ovl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (active),
        .cyc_end(cyc_end),
        .hit    (cyc_ilim),
        .trip   (trip_ovl)
    );

    fsup_cyc_cnt #(.LIMIT(MAXD_LIMIT), .UPDOWN(1'b0)) u_maxd (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (active),
        .cyc_end(cyc_end),
        .hit    (cyc_maxd),
        .trip   (trip_maxd)
    );

    assign trip_hot = hot && active;
    assign trip_any = trip_hot || trip_clamp || trip_dis || trip_minf || trip_ovl || trip_maxd;

    // Fixed-priority selection of the cause to latch.
    always_comb begin
        if (trip_hot)                    win = CAUSE_HOT;
        else if (trip_clamp)             win = CAUSE_CLAMP;
        else if (trip_dis)               win = CAUSE_DIS;
        else if (trip_ovl || trip_minf)  win = CAUSE_OVL;
        else if (trip_maxd)              win = CAUSE_MAXD;
        else                             win = CAUSE_NONE;
    end

    // Restart wait length depends on which fault was served.
    assign rlim = dis_wait ? RW'(DIS_RESTART_TICKS - 1) : RW'(RESTART_TICKS - 1);

    // Main sequencer: start, run, trip, wait, probe.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            state    <= ST_OFF;
            cause    <= CAUSE_NONE;
            rcnt     <= '0;
            dis_wait <= 1'b0;
        end else begin
            case (state)
                ST_OFF: state <= ST_SOFT;
                ST_SOFT, ST_RUN: begin
                    if (trip_any) begin
                        state    <= ST_WAIT;
                        cause    <= win;
                        dis_wait <= (win == CAUSE_DIS);
                        rcnt     <= '0;
                    end else if (state == ST_SOFT && ramp_done) begin
                        state <= ST_RUN;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (rcnt == rlim) begin
                            rcnt <= '0;
                            if (cause == CAUSE_HOT) begin
                                state <= ST_PROBE;
                            end else begin
                                state <= ST_SOFT;
                                cause <= CAUSE_NONE;
                            end
                        end else begin
                            rcnt <= rcnt + 1'b1;
                        end
                    end
                end
                ST_PROBE: begin
                    if (cyc_end) begin
                        if (hot) begin
                            state    <= ST_WAIT;
                            dis_wait <= 1'b0;
                            rcnt     <= '0;
                        end else begin
                            state <= ST_SOFT;
                            cause <= CAUSE_NONE;
                        end
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // Output decode from the sequencer state.
    always_comb begin
        pwm_en     = active || (state == ST_PROBE);
        fault_code = cause;
        case (state)
            ST_SOFT:  ilim_step = ramp_step;
            ST_RUN:   ilim_step = SW'(SS_STEPS);
            ST_PROBE: ilim_step = SW'(1);
            default:  ilim_step = '0;
        endcase
    end

    assert_supply_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!pwm_en && fault_code == 3'd0 && ilim_step == '0));

    assert_trip_stops_pwm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && trip_any && supply_ok) |=> !pwm_en);

    assert_hot_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hot && supply_ok) |=> (fault_code == 3'd1));

    assert_code_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state == ST_WAIT)) |-> $stable(fault_code));

    assert_probe_is_hot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE) |-> (fault_code == 3'd1 && ilim_step == SW'(1)));

endmodule

// File: tb/fault_supervisor_test.sv
// Directed bench for fault_supervisor with scaled timing.
module fault_supervisor_test;

    localparam int TK  = 2;   // clocks per tick
    localparam int SST = 3;   // ticks per soft-start step
    localparam int RST = 30;  // restart wait ticks
    localparam int DRS = 15;  // disable restart wait ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       cyc_end = 1'b0, cyc_ilim = 1'b0, cyc_maxd = 1'b0;
    logic       at_fmin = 1'b0, clamp_hi = 1'b0, dis_hi = 1'b0, hot = 1'b0;
    logic       pwm_en;
    logic [3:0] ilim_step;
    logic [2:0] fault_code;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fault_supervisor #(
        .TICK_CLKS(TK), .SS_STEPS(8), .SS_STEP_TICKS(SST), .CLAMP_TICKS(4),
        .DIS_TICKS(4), .MINF_TICKS(20), .RESTART_TICKS(RST),
        .DIS_RESTART_TICKS(DRS), .OVL_LIMIT(10), .MAXD_LIMIT(10)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cyc_end(cyc_end),
        .cyc_ilim(cyc_ilim), .cyc_maxd(cyc_maxd), .at_fmin(at_fmin),
        .clamp_hi(clamp_hi), .dis_hi(dis_hi), .hot(hot), .pwm_en(pwm_en),
        .ilim_step(ilim_step), .fault_code(fault_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_cycle(input bit lim, input bit md);
        @(negedge clk);
        cyc_end = 1'b1; cyc_ilim = lim; cyc_maxd = md;
        @(negedge clk);
        cyc_end = 1'b0; cyc_ilim = 1'b0; cyc_maxd = 1'b0;
        clocks(1);
    endtask

    task automatic off_time(output int n);
        n = 0;
        while (!pwm_en && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_run(input string req);
        int n = 0;
        while (!(pwm_en && ilim_step == 4'd8) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        clocks(SST * TK + 4);
        check(pwm_en && ilim_step == 4'd8 && fault_code == 3'd0, req, "reach run",
              int'(ilim_step), 8);
    endtask

    task automatic t_reset();
        clocks(3);
        check(!pwm_en && ilim_step == 0 && fault_code == 0, "R1", "in reset",
              int'(pwm_en), 0);
        rst_n = 1'b1;
        clocks(5);
        check(!pwm_en && ilim_step == 0, "R1", "no supply", int'(pwm_en), 0);
    endtask

    task automatic t_softstart();
        int prev = 0, bad = 0, t = 0;
        supply_ok = 1'b1;
        @(negedge clk);
        check(pwm_en && ilim_step == 1, "R2", "first step", int'(ilim_step), 1);
        prev = 1;
        while (ilim_step != 4'd8 && t < 300) begin
            @(negedge clk);
            t++;
            if (int'(ilim_step) != prev) begin
                if (int'(ilim_step) != prev + 1) bad++;
                prev = int'(ilim_step);
            end
        end
        check(bad == 0, "R2", "unit steps", bad, 0);
        check(t >= 7 * SST * TK - 2 && t <= 7 * SST * TK + 2, "R2", "ramp time",
              t, 7 * SST * TK);
        wait_run("R2");
    endtask

    task automatic t_overload();
        int n;
        for (int i = 0; i < 15; i++) begin
            run_cycle(1'b1, 1'b0);
            run_cycle(1'b0, 1'b0);
        end
        check(pwm_en && fault_code == 0, "R3", "alternating no trip", int'(fault_code), 0);
        for (int i = 0; i < 9; i++) run_cycle(1'b1, 1'b0);
        check(pwm_en, "R3", "9 limited cycles", int'(pwm_en), 1);
        run_cycle(1'b1, 1'b0);
        check(!pwm_en && fault_code == 4, "R3", "trip code", int'(fault_code), 4);
        off_time(n);
        check(n >= RST * TK - 4 && n <= RST * TK + 4, "R8", "restart wait", n, RST * TK);
        check(ilim_step == 1 && fault_code == 0, "R8", "restart soft step",
              int'(ilim_step), 1);
        wait_run("R8");
    endtask

    task automatic t_minfreq();
        at_fmin = 1'b1;
        clocks(30);
        check(pwm_en, "R4", "before limit", int'(pwm_en), 1);
        clocks(20);
        check(!pwm_en && fault_code == 4, "R4", "min freq trip", int'(fault_code), 4);
        at_fmin = 1'b0;
        clocks(20);
        check(!pwm_en && fault_code == 4, "R11", "code held in wait", int'(fault_code), 4);
        wait_run("R4");
    endtask

    task automatic t_maxduty();
        for (int i = 0; i < 9; i++) run_cycle(1'b0, 1'b1);
        run_cycle(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) run_cycle(1'b0, 1'b1);
        check(pwm_en && fault_code == 0, "R5", "broken run no trip", int'(fault_code), 0);
        run_cycle(1'b0, 1'b1);
        check(!pwm_en && fault_code == 5, "R5", "tenth cycle trip", int'(fault_code), 5);
        wait_run("R5");
    endtask

    task automatic t_clamp();
        int n, bad = 0;
        clamp_hi = 1'b1;
        clocks(4);
        clamp_hi = 1'b0;
        clocks(10);
        check(pwm_en && fault_code == 0, "R6", "short clamp", int'(fault_code), 0);
        clamp_hi = 1'b1;
        clocks(14);
        check(!pwm_en && fault_code == 2, "R6", "clamp trip", int'(fault_code), 2);
        off_time(n);
        while (ilim_step != 4'd8 && n < 2000) begin
            if (!pwm_en || fault_code != 0) bad++;
            @(negedge clk);
            n++;
        end
        check(bad == 0, "R6", "ignored in soft-start", bad, 0);
        clocks(20);
        check(!pwm_en && fault_code == 2, "R6", "clamp after soft", int'(fault_code), 2);
        clamp_hi = 1'b0;
        wait_run("R6");
    endtask

    task automatic t_disable();
        int n;
        dis_hi = 1'b1;
        clocks(5);
        dis_hi = 1'b0;
        clocks(10);
        check(pwm_en && fault_code == 0, "R7", "short excursion", int'(fault_code), 0);
        dis_hi = 1'b1;
        clocks(12);
        check(!pwm_en && fault_code == 3, "R7", "disable trip", int'(fault_code), 3);
        dis_hi = 1'b0;
        off_time(n);
        check(n >= DRS * TK - 8 && n <= DRS * TK + 4, "R7", "short restart", n, DRS * TK);
        wait_run("R7");
    endtask

    task automatic t_hot();
        int n;
        @(negedge clk);
        hot = 1'b1;
        clocks(2);
        check(!pwm_en && fault_code == 1, "R9", "hot trip", int'(fault_code), 1);
        off_time(n);
        check(n >= RST * TK - 6 && n <= RST * TK + 4, "R8", "hot wait", n, RST * TK);
        clocks(10);
        check(pwm_en && ilim_step == 1 && fault_code == 1, "R9", "probe holds",
              int'(ilim_step), 1);
        run_cycle(1'b0, 1'b0);
        check(!pwm_en && fault_code == 1, "R9", "still hot", int'(fault_code), 1);
        hot = 1'b0;
        off_time(n);
        check(ilim_step == 1 && fault_code == 1, "R9", "second probe", int'(fault_code), 1);
        run_cycle(1'b0, 1'b0);
        check(pwm_en && fault_code == 0, "R9", "cool restart", int'(fault_code), 0);
        clocks(SST * TK + 2);
        check(ilim_step == 2, "R9", "ramp after probe", int'(ilim_step), 2);
        wait_run("R9");
    endtask

    task automatic t_priority();
        @(negedge clk);
        clamp_hi = 1'b1; dis_hi = 1'b1;
        clocks(14);
        check(fault_code == 2, "R10", "clamp over disable", int'(fault_code), 2);
        clamp_hi = 1'b0; dis_hi = 1'b0;
        wait_run("R10");
        for (int i = 0; i < 10; i++) run_cycle(1'b1, 1'b1);
        check(!pwm_en && fault_code == 4, "R10", "overload over max-duty",
              int'(fault_code), 4);
        wait_run("R10");
    endtask

    task automatic t_supply();
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check(!pwm_en && ilim_step == 0 && fault_code == 0, "R1", "supply drop run",
              int'(pwm_en), 0);
        supply_ok = 1'b1;
        wait_run("R1");
        hot = 1'b1;
        clocks(3);
        hot = 1'b0;
        supply_ok = 1'b0;
        @(negedge clk);
        check(fault_code == 0 && !pwm_en, "R1", "supply drop in wait", int'(fault_code), 0);
        supply_ok = 1'b1;
        @(negedge clk);
        check(pwm_en && ilim_step == 1, "R1", "restart at once", int'(ilim_step), 1);
    endtask

    initial begin
        t_reset();
        t_softstart();
        t_overload();
        t_minfreq();
        t_maxduty();
        t_clamp();
        t_disable();
        t_hot();
        t_priority();
        t_supply();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule